// File: doc/BRIEF.md
# MMU Control Register File

This block is the memory-mapped register file that holds the address-translation and exception state of a processor core. Software reaches it through a simple single-beat access port carrying an offset, an access size and write data. It stores the translation control word, the page-entry high, low and auxiliary words, the translation table base, the faulting address and three event/trap code words. It also serves three read-only identification words, a group of inert memory-interface control slots that always read zero, and a 16-bit refresh counter that advances each time it is read.

Certain writes have effects beyond storage. They drive one-cycle pulses toward an external translation buffer. Setting the invalidate bit in the control word requests a full invalidate, and that bit is never kept. Changing the address-space identifier, held in the low byte of the page-entry high word, requests a flush. Each access is answered exactly one cycle later with read data, a bus-error flag and the side-effect pulses.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: After reset every writable register reads as zero, and the bus-error and side-effect outputs are low.
- R2: The control word (offset 0x00), page-entry high (0x04), page-entry low (0x08), table base (0x0C) and fault address (0x10) are 32-bit word registers that read back what was written. The control word is the exception to this: see R3.
- R3: A word write to the control word with bit 2 set raises `tlb_inval_o` for one cycle. The stored value always has bit 2 cleared. A write with bit 2 clear raises no pulse.
- R4: A word write to page-entry high whose bits 7:0 differ from the stored bits 7:0 raises `tlb_flush_o` for one cycle. If bits 7:0 are equal, there is no pulse. In both cases the full word is stored.
- R5: The trap code (0x20), exception code (0x24) and interrupt code (0x28) keep only bits 10:0 of the written data. Their upper bits read as zero.
- R6: The page-entry auxiliary word (0x14) keeps only bits 3:0 of the written data.
- R7: Word reads at 0x30, 0x40 and 0x44 return the parameter values for version, cache identification and revision. A write to any of these offsets raises a bus error and changes nothing.
- R8: The refresh counter at 0x60 is accessed as a halfword. A read returns the current value and then increments it, wrapping from 0xFFFF to 0. A write loads bits 15:0.
- R9: Word accesses at 0x50, 0x54, 0x58 and 0x5C read as zero. Writes to these offsets are ignored without error.
- R10: An access to an unmapped offset, or with a size other than the slot's size, raises `berr_o`, returns zero and changes no state. The size encoding is 0 for a byte, 1 for a halfword, 2 for a word and 3 is invalid.
- R11: Every accepted request produces `rsp_vld_o` for exactly one cycle, in the cycle after the request. The response carries `rdata_o`, `berr_o` and the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the slot |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| wdata_i | input | 32 | Write data |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| rdata_o | output | 32 | Read data, zero on writes and errors |
| berr_o | output | 1 | Bus error for bad offset, size or read-only write |
| tlb_inval_o | output | 1 | One-cycle full-invalidate pulse |
| tlb_flush_o | output | 1 | One-cycle address-space flush pulse |

## Verification
The hardest conditions to reach are the ones that depend on state history rather than on a single access. A flush must appear only when the new identifier byte differs from the stored one. The stimulus therefore first writes a page-entry value whose low byte matches the reset value. It then writes one that differs, and then one that differs only in the upper bits. The refresh counter's wrap is reached by loading 0xFFFE through a write and then reading three times in a row. Each rejected access is followed by a read-back, which shows that the access left no trace in the registers.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  localparam int DATA_W   = 32;
  localparam int CODE_W   = 11;
  localparam int AUX_W    = 4;
  localparam int ASID_W   = 8;
  localparam int INVAL_BIT = 2;
  localparam int RFC_W    = 16;
  localparam int N_CODES  = 3;

  localparam int OFF_CTRL     = 'h00;
  localparam int OFF_ENTRY_HI = 'h04;
  localparam int OFF_ENTRY_LO = 'h08;
  localparam int OFF_TBL_BASE = 'h0C;
  localparam int OFF_FAULT    = 'h10;
  localparam int OFF_AUX      = 'h14;
  localparam int OFF_CODE0    = 'h20;
  localparam int OFF_ID_VER   = 'h30;
  localparam int OFF_ID_CACHE = 'h40;
  localparam int OFF_ID_REV   = 'h44;
  localparam int OFF_QUIET0   = 'h50;
  localparam int N_QUIET      = 4;
  localparam int OFF_REFRESH  = 'h60;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_CTRL,
    RS_ENTRY_HI,
    RS_ENTRY_LO,
    RS_TBL_BASE,
    RS_FAULT,
    RS_AUX,
    RS_CODE0,
    RS_CODE1,
    RS_CODE2,
    RS_ID_VER,
    RS_ID_CACHE,
    RS_ID_REV,
    RS_QUIET,
    RS_REFRESH
  } reg_sel_e;

  typedef struct packed {
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] entry_hi;
    logic [DATA_W-1:0] entry_lo;
    logic [DATA_W-1:0] tbl_base;
    logic [DATA_W-1:0] fault;
    logic [DATA_W-1:0] aux;
  } mmu_state_t;

endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              ok_o
);

  reg_sel_e  sel;
  acc_size_e need;
  logic      ro;

  always_comb begin
    sel  = RS_NONE;
    need = SZ_WORD;
    ro   = 1'b0;
    for (int q = 0; q < N_QUIET; q++) begin
      if (addr_i == ADDR_W'(OFF_QUIET0 + 4*q)) sel = RS_QUIET;
    end
    for (int c = 0; c < N_CODES; c++) begin
      if (addr_i == ADDR_W'(OFF_CODE0 + 4*c)) sel = reg_sel_e'(int'(RS_CODE0) + c);
    end
    if (addr_i == ADDR_W'(OFF_CTRL))     sel = RS_CTRL;
    if (addr_i == ADDR_W'(OFF_ENTRY_HI)) sel = RS_ENTRY_HI;
    if (addr_i == ADDR_W'(OFF_ENTRY_LO)) sel = RS_ENTRY_LO;
    if (addr_i == ADDR_W'(OFF_TBL_BASE)) sel = RS_TBL_BASE;
    if (addr_i == ADDR_W'(OFF_FAULT))    sel = RS_FAULT;
    if (addr_i == ADDR_W'(OFF_AUX))      sel = RS_AUX;
    if (addr_i == ADDR_W'(OFF_ID_VER))   sel = RS_ID_VER;
    if (addr_i == ADDR_W'(OFF_ID_CACHE)) sel = RS_ID_CACHE;
    if (addr_i == ADDR_W'(OFF_ID_REV))   sel = RS_ID_REV;
    if (addr_i == ADDR_W'(OFF_REFRESH)) begin
      sel  = RS_REFRESH;
      need = SZ_HALF;
    end
    ro = (sel == RS_ID_VER) || (sel == RS_ID_CACHE) || (sel == RS_ID_REV);
  end

  assign sel_o = sel;
  assign ok_o  = (sel != RS_NONE) && (size_i == need) && !(we_i && ro);

endmodule

// File: rtl/mmu_reg_store.sv
module mmu_reg_store
  import mmu_ctl_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  reg_sel_e                        sel_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output mmu_state_t                      st_o,
  output logic [N_CODES-1:0][DATA_W-1:0]  codes_o,
  output logic                            inval_o,
  output logic                            flush_o
);

  localparam logic [DATA_W-1:0] INVAL_MASK = ~(DATA_W'(1) << INVAL_BIT);

  mmu_state_t st_q, st_d;

  always_comb begin
    st_d    = st_q;
    inval_o = 1'b0;
    flush_o = 1'b0;
    if (wr_en_i) begin
      case (sel_i)
        RS_CTRL: begin
          inval_o  = wdata_i[INVAL_BIT];
          st_d.ctrl = wdata_i & INVAL_MASK;
        end
        RS_ENTRY_HI: begin
          flush_o       = wdata_i[ASID_W-1:0] != st_q.entry_hi[ASID_W-1:0];
          st_d.entry_hi = wdata_i;
        end
        RS_ENTRY_LO: st_d.entry_lo = wdata_i;
        RS_TBL_BASE: st_d.tbl_base = wdata_i;
        RS_FAULT:    st_d.fault    = wdata_i;
        RS_AUX:      st_d.aux      = {{(DATA_W-AUX_W){1'b0}}, wdata_i[AUX_W-1:0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    logic              en;
    logic [CODE_W-1:0] code_q;
    assign en = wr_en_i && (sel_i == reg_sel_e'(int'(RS_CODE0) + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q <= '0;
      else if (en) code_q <= wdata_i[CODE_W-1:0];
    end
    assign codes_o[g] = {{(DATA_W-CODE_W){1'b0}}, code_q};
  end

  // R3: the invalidate request bit never survives into storage
  a_r3_inval_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.ctrl[INVAL_BIT]);
  // R6: auxiliary word never holds bits above its field
  a_r6_aux_width: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.aux >> AUX_W) == '0);
  // R4: entry-high may only change through a write cycle
  a_r4_hi_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(st_q.entry_hi));

endmodule

// File: rtl/mmu_refresh_ctr.sv
module mmu_refresh_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = rd_en_i || wr_en_i;
    cnt_d  = wr_en_i ? wdata_i : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8: each read advances the counter by exactly one, modulo width
  a_r8_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i) |=> cnt_q == $past(cnt_q) + W'(1));

endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
  import mmu_ctl_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] VER_ID   = 32'h0A11_0C07,
  parameter logic [31:0] CACHE_ID = 32'h2000_8403,
  parameter logic [31:0] REV_ID   = 32'h0000_0113
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              rsp_vld_o,
  output logic [31:0]       rdata_o,
  output logic              berr_o,
  output logic              tlb_inval_o,
  output logic              tlb_flush_o
);

  reg_sel_e                        sel;
  logic                            acc_ok;
  logic                            wr_en, rd_en;
  mmu_state_t                      st;
  logic [N_CODES-1:0][DATA_W-1:0]  codes;
  logic                            inval_d, flush_d;
  logic [RFC_W-1:0]                rfc;
  logic [DATA_W-1:0]               rmux;

  logic              vld_q, berr_q, inval_q, flush_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              vld_d, berr_d;

  mmu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .we_i   (we_i),
    .sel_o  (sel),
    .ok_o   (acc_ok)
  );

  assign wr_en = req_i && we_i && acc_ok;
  assign rd_en = req_i && !we_i && acc_ok;

  mmu_reg_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .st_o    (st),
    .codes_o (codes),
    .inval_o (inval_d),
    .flush_o (flush_d)
  );

  mmu_refresh_ctr #(.W(RFC_W)) u_rfc (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en && (sel == RS_REFRESH)),
    .wr_en_i (wr_en && (sel == RS_REFRESH)),
    .wdata_i (wdata_i[RFC_W-1:0]),
    .cnt_o   (rfc)
  );

  always_comb begin
    case (sel)
      RS_CTRL:     rmux = st.ctrl;
      RS_ENTRY_HI: rmux = st.entry_hi;
      RS_ENTRY_LO: rmux = st.entry_lo;
      RS_TBL_BASE: rmux = st.tbl_base;
      RS_FAULT:    rmux = st.fault;
      RS_AUX:      rmux = st.aux;
      RS_CODE0:    rmux = codes[0];
      RS_CODE1:    rmux = codes[1];
      RS_CODE2:    rmux = codes[2];
      RS_ID_VER:   rmux = VER_ID;
      RS_ID_CACHE: rmux = CACHE_ID;
      RS_ID_REV:   rmux = REV_ID;
      RS_REFRESH:  rmux = {{(DATA_W-RFC_W){1'b0}}, rfc};
      default:     rmux = '0;
    endcase
  end

  always_comb begin
    vld_d   = req_i;
    berr_d  = req_i && !acc_ok;
    rdata_d = rd_en ? rmux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      berr_q  <= 1'b0;
      inval_q <= 1'b0;
      flush_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      vld_q   <= vld_d;
      berr_q  <= berr_d;
      inval_q <= inval_d;
      flush_q <= flush_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_vld_o   = vld_q;
  assign berr_o      = berr_q;
  assign tlb_inval_o = inval_q;
  assign tlb_flush_o = flush_q;
  assign rdata_o     = rdata_q;

  // R11: a request is always answered in the next cycle
  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rsp_vld_o);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rsp_vld_o);
  // R10: an error response carries no data
  a_r10_berr_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> (rdata_o == '0) && rsp_vld_o);
  // R3: invalidate pulses only accompany a good response
  a_r3_inval_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval_o |-> rsp_vld_o && !berr_o);
  // R4: a flush pulse coincides with a changed identifier byte
  a_r4_flush_asid_moved: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |-> rsp_vld_o && (st.entry_hi[ASID_W-1:0] != $past(st.entry_hi[ASID_W-1:0])));

endmodule

// File: tb/mmu_ctl_regfile_tb_top.sv
module mmu_ctl_regfile_tb_top;

  localparam logic [31:0] T_VER   = 32'h1357_9BDF;
  localparam logic [31:0] T_CACHE = 32'h2468_ACE0;
  localparam logic [31:0] T_REV   = 32'h0000_0A5C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, we_i;
  logic [7:0]  addr_i;
  logic [1:0]  size_i;
  logic [31:0] wdata_i;
  logic        rsp_vld_o, berr_o, tlb_inval_o, tlb_flush_o;
  logic [31:0] rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] r_data;
  logic        r_vld, r_berr, r_inval, r_flush;

  always #10 clk = ~clk;

  mmu_ctl_regfile #(.ADDR_W(8), .VER_ID(T_VER), .CACHE_ID(T_CACHE), .REV_ID(T_REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rsp_vld_o(rsp_vld_o), .rdata_o(rdata_o),
    .berr_o(berr_o), .tlb_inval_o(tlb_inval_o), .tlb_flush_o(tlb_flush_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    r_data = rdata_o; r_vld = rsp_vld_o; r_berr = berr_o;
    r_inval = tlb_inval_o; r_flush = tlb_flush_o;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp, input string req);
    access(1'b0, a, sz, 0);
    chk(r_data == exp && !r_berr && r_vld, req, r_data, exp);
  endtask

  task automatic t_reset;
    chk(!rsp_vld_o && !berr_o && !tlb_inval_o && !tlb_flush_o, "R1 idle outputs",
        {28'd0, rsp_vld_o, berr_o, tlb_inval_o, tlb_flush_o}, 0);
    rd_expect(8'h00, 2'd2, 0, "R1 ctrl reset");
    rd_expect(8'h04, 2'd2, 0, "R1 entry_hi reset");
    rd_expect(8'h0C, 2'd2, 0, "R1 table base reset");
    rd_expect(8'h24, 2'd2, 0, "R1 exc code reset");
    rd_expect(8'h60, 2'd1, 0, "R1 refresh reset");
  endtask

  task automatic t_words;
    access(1'b1, 8'h08, 2'd2, 32'hDEAD_BEEF);
    access(1'b1, 8'h0C, 2'd2, 32'h8001_2000);
    access(1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF);
    rd_expect(8'h08, 2'd2, 32'hDEAD_BEEF, "R2 entry_lo");
    rd_expect(8'h0C, 2'd2, 32'h8001_2000, "R2 table base");
    rd_expect(8'h10, 2'd2, 32'hFFFF_FFFF, "R2 fault addr");
  endtask

  task automatic t_inval;
    access(1'b1, 8'h00, 2'd2, 32'h0000_0105);
    chk(r_inval && r_vld, "R3 inval pulse", {31'd0, r_inval}, 1);
    @(negedge clk);
    chk(!tlb_inval_o && !rsp_vld_o, "R11 R3 pulse one cycle", {31'd0, tlb_inval_o}, 0);
    rd_expect(8'h00, 2'd2, 32'h0000_0101, "R3 bit cleared");
    access(1'b1, 8'h00, 2'd2, 32'h0000_0001);
    chk(!r_inval, "R3 no pulse without bit", {31'd0, r_inval}, 0);
  endtask

  task automatic t_asid;
    access(1'b1, 8'h04, 2'd2, 32'h1234_5600);
    chk(!r_flush, "R4 same asid no flush", {31'd0, r_flush}, 0);
    access(1'b1, 8'h04, 2'd2, 32'hAAAA_AA42);
    chk(r_flush, "R4 changed asid flush", {31'd0, r_flush}, 1);
    access(1'b1, 8'h04, 2'd2, 32'h0000_0042);
    chk(!r_flush, "R4 upper-only change no flush", {31'd0, r_flush}, 0);
    rd_expect(8'h04, 2'd2, 32'h0000_0042, "R4 stored value");
  endtask

  task automatic t_codes;
    access(1'b1, 8'h20, 2'd2, 32'hFFFF_FFFF);
    access(1'b1, 8'h24, 2'd2, 32'h1234_5C3A);
    access(1'b1, 8'h28, 2'd2, 32'h0000_0800);
    rd_expect(8'h20, 2'd2, 32'h0000_07FF, "R5 trap code");
    rd_expect(8'h24, 2'd2, 32'h0000_043A, "R5 exc code");
    rd_expect(8'h28, 2'd2, 32'h0000_0000, "R5 irq code");
  endtask

  task automatic t_aux;
    access(1'b1, 8'h14, 2'd2, 32'hFFFF_FFFA);
    rd_expect(8'h14, 2'd2, 32'h0000_000A, "R6 aux width");
  endtask

  task automatic t_ids;
    rd_expect(8'h30, 2'd2, T_VER, "R7 version");
    rd_expect(8'h40, 2'd2, T_CACHE, "R7 cache id");
    rd_expect(8'h44, 2'd2, T_REV, "R7 revision");
    access(1'b1, 8'h30, 2'd2, 32'h0);
    chk(r_berr, "R7 write berr", {31'd0, r_berr}, 1);
    rd_expect(8'h30, 2'd2, T_VER, "R7 id unchanged");
  endtask

  task automatic t_refresh;
    access(1'b1, 8'h60, 2'd1, 32'h1234_FFFE);
    chk(!r_berr, "R8 write ok", {31'd0, r_berr}, 0);
    rd_expect(8'h60, 2'd1, 32'h0000_FFFE, "R8 first read");
    rd_expect(8'h60, 2'd1, 32'h0000_FFFF, "R8 increment");
    rd_expect(8'h60, 2'd1, 32'h0000_0000, "R8 wrap");
    rd_expect(8'h60, 2'd1, 32'h0000_0001, "R8 after wrap");
  endtask

  task automatic t_quiet;
    access(1'b1, 8'h50, 2'd2, 32'hFFFF_FFFF);
    chk(!r_berr, "R9 write no error", {31'd0, r_berr}, 0);
    rd_expect(8'h50, 2'd2, 0, "R9 reads zero");
    access(1'b1, 8'h5C, 2'd2, 32'h5555_5555);
    rd_expect(8'h5C, 2'd2, 0, "R9 last slot zero");
  endtask

  task automatic t_errors;
    access(1'b0, 8'h7C, 2'd2, 0);
    chk(r_berr && r_data == 0 && r_vld, "R10 unmapped", r_data, 0);
    access(1'b0, 8'h00, 2'd1, 0);
    chk(r_berr && r_data == 0, "R10 half on word slot", r_data, 0);
    access(1'b1, 8'h0C, 2'd0, 32'h1111_1111);
    chk(r_berr, "R10 byte write berr", {31'd0, r_berr}, 1);
    rd_expect(8'h0C, 2'd2, 32'h8001_2000, "R10 table base unchanged");
    access(1'b0, 8'h60, 2'd2, 0);
    chk(r_berr, "R10 word on refresh", {31'd0, r_berr}, 1);
    rd_expect(8'h60, 2'd1, 32'h0000_0002, "R10 refresh not advanced");
    access(1'b1, 8'h04, 2'd3, 32'h0000_0099);
    chk(r_berr && !r_flush, "R10 bad size no flush", {31'd0, r_flush}, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; size_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_words();
    t_inval();
    t_asid();
    t_codes();
    t_aux();
    t_ids();
    t_refresh();
    t_quiet();
    t_errors();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule